// File: doc/BRIEF.md
# Bus Request and Parking Controller

This block drives the bus-request line of one master on a shared external bus. The request follows two things: whether the core has an external access pending, and a software hold control that can force the request on when no access is pending. Stop and wait low-power states either clear the request or freeze it, depending on the hold control. Accesses to the internal bus are never presented to this block, so they cannot raise the request.

The block also tracks ownership. It becomes master one clock after a grant is seen while no other master is driving the bus. It stays master for as long as the grant remains, even after its own request has dropped; this is bus parking. Ownership is lost at the clock edge after the grant is removed. While an external access is pending and the block is not yet master, a stall output holds the core back.

Top module: `bus_req_park_ctrl`

## Requirements
- R1: While rst_ni is low, br_o and master_o are 0, whatever the other inputs are.
- R2: With every lp_i bit at 0, br_o after a rising clock edge equals ext_pend_i OR hold_i as sampled at that edge.
- R3: With no low-power bit set, br_o falls one clock after ext_pend_i and hold_i are both 0.
- R4: With hold_i at 1 and ext_pend_i at 0, outside low power, br_o is 1 after the next clock.
- R5: While any lp_i bit is 1 and hold_i is 0, br_o is 0 after the next clock, even if ext_pend_i is 1.
- R6: While any lp_i bit is 1 and hold_i is 1, br_o keeps its previous value across the clock, whether that value is 0 or 1.
- R7: When the block is slave, grant_i is 1 and busy_i is 0 at a clock edge, master_o is 1 after that edge.
- R8: When the block is slave and busy_i is 1, master_o stays 0 across the clock, even with grant_i at 1.
- R9: When grant_i is 0 at a clock edge, master_o is 0 after that edge.
- R10: When master_o is 1 and grant_i stays 1, master_o stays 1, whatever br_o, ext_pend_i and hold_i are (parking).
- R11: stall_o is combinationally ext_pend_i AND NOT master_o.
- R12: grant_i and busy_i have no effect on br_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pend_i | input | 1 | Core has an external-bus access pending |
| hold_i | input | 1 | Software request-hold control |
| lp_i | input | LP_W | Low-power indications, one bit per state (default: bit 0 stop, bit 1 wait) |
| grant_i | input | 1 | Bus grant from the external arbiter |
| busy_i | input | 1 | Another master is still driving the bus |
| br_o | output | 1 | Bus request to the arbiter |
| master_o | output | 1 | Block currently owns the bus |
| stall_o | output | 1 | Core-side external access must wait for ownership |

## Verification
The request path is tried with isolated pending pulses, hold alone, both together and both dropping, so that the one-clock latency and the OR of the two sources can be told apart from a level copy of either. Low-power is entered with the request high and low, with hold clear and set, which separates clearing from freezing and shows that a frozen low request stays low. Ownership is exercised with grant against an idle and a busy bus, with grant held after the request drops (parking) and with grant toggled under a constant request, which shows that ownership and request are decoupled. A long pseudo-random stretch then mixes all inputs against the bench's model every clock.

// File: rtl/bus_park_pkg.sv
`timescale 1ns/1ps
package bus_park_pkg;
  typedef enum logic {
    OWN_SLAVE  = 1'b0,
    OWN_MASTER = 1'b1
  } own_state_e;
endpackage

// File: rtl/br_req_gen.sv
`timescale 1ns/1ps
module br_req_gen #(
  parameter int LP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_pend_i,
  input  logic            hold_i,
  input  logic [LP_W-1:0] lp_i,
  output logic            br_o
);
  logic lp_any;
  logic br_q, br_d;

  assign lp_any = |lp_i;

  always_comb begin
    if (lp_any) br_d = hold_i ? br_q : 1'b0;
    else        br_d = ext_pend_i | hold_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) br_q <= 1'b0;
    else         br_q <= br_d;
  end

  assign br_o = br_q;

  // R2
  br_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_any) |=> (br_o == $past(ext_pend_i | hold_i)));
  // R5
  br_lp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_any && !hold_i) |=> !br_o);
  // R6
  br_lp_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_any && hold_i) |=> $stable(br_o));
endmodule

// File: rtl/own_tracker.sv
`timescale 1ns/1ps
module own_tracker
  import bus_park_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic busy_i,
  input  logic ext_pend_i,
  output logic master_o,
  output logic stall_o
);
  own_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_SLAVE:  if (grant_i && !busy_i) state_d = OWN_MASTER;
      OWN_MASTER: if (!grant_i)           state_d = OWN_SLAVE;
      default:                            state_d = OWN_SLAVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OWN_SLAVE;
    else         state_q <= state_d;
  end

  assign master_o = (state_q == OWN_MASTER);
  assign stall_o  = ext_pend_i & ~master_o;

  // R7
  own_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_o && grant_i && !busy_i) |=> master_o);
  // R8
  own_busy_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_o && busy_i) |=> !master_o);
  // R9
  own_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_i |=> !master_o);
  // R10
  own_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o && grant_i) |=> master_o);
endmodule

// File: rtl/bus_req_park_ctrl.sv
`timescale 1ns/1ps
module bus_req_park_ctrl #(
  parameter int LP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_pend_i,
  input  logic            hold_i,
  input  logic [LP_W-1:0] lp_i,
  input  logic            grant_i,
  input  logic            busy_i,
  output logic            br_o,
  output logic            master_o,
  output logic            stall_o
);
  br_req_gen #(.LP_W(LP_W)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_pend_i (ext_pend_i),
    .hold_i     (hold_i),
    .lp_i       (lp_i),
    .br_o       (br_o)
  );

  own_tracker u_own (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant_i),
    .busy_i     (busy_i),
    .ext_pend_i (ext_pend_i),
    .master_o   (master_o),
    .stall_o    (stall_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!br_o && !master_o));
  // R11
  always_comb begin
    if (rst_ni) stall_match_chk: assert (stall_o == (ext_pend_i && !master_o));
  end
endmodule

// File: tb/bus_req_park_ctrl_tb.sv
`timescale 1ns/1ps
module bus_req_park_ctrl_tb;
  localparam int LP_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend = 1'b0, hold = 1'b0, grant = 1'b0, busy = 1'b0;
  logic [LP_W-1:0] lp = '0;
  logic br, master, stall;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference state
  int m_br = 0;
  int m_master = 0;

  always #2.5 clk = ~clk;

  bus_req_park_ctrl #(.LP_W(LP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pend_i(pend), .hold_i(hold),
    .lp_i(lp), .grant_i(grant), .busy_i(busy),
    .br_o(br), .master_o(master), .stall_o(stall)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_br = 0;
      m_master = 0;
    end else begin
      if (lp != 0) begin
        if (!hold) m_br = 0;
      end else begin
        m_br = (pend || hold) ? 1 : 0;
      end
      if (!grant) m_master = 0;
      else if (m_master == 0 && !busy) m_master = 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("br_o", int'(br), m_br);
    chk("master_o", int'(master), m_master);
    chk("stall_o R11", int'(stall), (pend && m_master == 0) ? 1 : 0);
  endtask

  // drive at negedge, compare at next negedge
  task automatic cyc(input logic p, input logic h, input logic [LP_W-1:0] l,
                     input logic g, input logic b);
    pend = p; hold = h; lp = l; grant = g; busy = b;
    #0.1 chk("stall_o R11 comb", int'(stall), (p && master == 1'b0) ? 1 : 0);
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    // R1: reset dominates with active inputs
    tag = "R1";
    pend = 1; hold = 1; grant = 1; busy = 0;
    repeat (3) begin
      @(negedge clk);
      chk("br_o reset", int'(br), 0);
      chk("master_o reset", int'(master), 0);
    end
    pend = 0; hold = 0; grant = 0;
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    tag = "R2";
    cyc(1, 0, 2'b00, 0, 0);
    cyc(0, 0, 2'b00, 0, 0);
    cyc(1, 0, 2'b00, 0, 0);
    cyc(1, 1, 2'b00, 0, 0);
    tag = "R3";
    cyc(0, 0, 2'b00, 0, 0);
    cyc(0, 0, 2'b00, 0, 0);
    tag = "R4";
    cyc(0, 1, 2'b00, 0, 0);
    cyc(0, 1, 2'b00, 0, 0);
    cyc(0, 0, 2'b00, 0, 0);

    tag = "R5";
    cyc(1, 0, 2'b00, 0, 0);
    cyc(1, 0, 2'b01, 0, 0);
    cyc(1, 0, 2'b10, 0, 0);
    cyc(1, 0, 2'b00, 0, 0);

    tag = "R6";
    cyc(1, 1, 2'b01, 0, 0);
    cyc(0, 1, 2'b01, 0, 0);
    cyc(0, 1, 2'b10, 0, 0);
    cyc(0, 0, 2'b00, 0, 0);
    cyc(1, 1, 2'b10, 0, 0);
    cyc(1, 1, 2'b11, 0, 0);
    cyc(0, 0, 2'b00, 0, 0);

    tag = "R8";
    cyc(1, 0, 2'b00, 1, 1);
    cyc(1, 0, 2'b00, 1, 1);
    tag = "R7";
    cyc(1, 0, 2'b00, 1, 0);
    cyc(1, 0, 2'b00, 1, 0);
    tag = "R10";
    cyc(0, 0, 2'b00, 1, 0);
    cyc(0, 0, 2'b00, 1, 1);
    cyc(0, 0, 2'b01, 1, 0);
    cyc(0, 1, 2'b00, 1, 0);
    tag = "R9";
    cyc(0, 0, 2'b00, 0, 0);
    cyc(1, 0, 2'b00, 0, 0);

    tag = "R12";
    cyc(1, 0, 2'b00, 1, 0);
    cyc(1, 0, 2'b00, 0, 1);
    cyc(1, 0, 2'b00, 1, 1);
    cyc(0, 0, 2'b00, 1, 0);
    cyc(0, 0, 2'b00, 0, 0);

    tag = "R2 R5 R6 R7 R8 R9 R10 R12 random";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0], lfsr[1] & lfsr[2], {lfsr[3] & lfsr[4], lfsr[5] & lfsr[6]},
            lfsr[7] | lfsr[8], lfsr[9] & lfsr[10]);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule